// File: doc/BRIEF.md
# Phase-One Serial Byte Master

This block moves one byte at a time over a four-wire synchronous serial link as the clock master. Outgoing data is sampled by the remote device on the second edge of each bit cell, and the master shifts its next bit out on the first edge. The host hands bytes over on a valid/ready stream. It reads the byte that came back from a register output, and it watches a sticky completion flag that it clears with a one-cycle pulse. The idle level of the serial clock is chosen by a polarity input. The bit order is chosen by a separate input. The clock half-period is set by an 8-bit divider input.

The host offers a byte with `tx_valid` and `tx_data`. The byte is taken on any clock edge where `tx_ready` is also high. `tx_ready` is high exactly when the single holding slot is empty, and it drops while a byte waits in that slot. The host must then hold `tx_valid` and `tx_data` unchanged until the slot frees. When the holding slot is already occupied at the moment a transfer finishes, the next byte follows at once. In that case the select line stays low and no trailing or idle gap is inserted.

Top module: `spi_cpha1_master`

## Requirements
- R1: Each byte uses exactly 16 serial clock edges, spaced H = half_div+1 clock cycles apart. The odd edges move `sck` away from its idle level, and the idle level equals `cpol` whenever `ss_n` is high.
- R2: `mosi` changes only on odd-numbered edges, and `miso` is captured on even-numbered edges.
- R3: With `lsb_first`=0, bit 7 is sent first and the first bit captured lands in bit 7 of `rx_data`. With `lsb_first`=1, bit 0 is sent first and the first bit captured lands in bit 0.
- R4: The first edge of a transfer started from idle comes exactly H cycles after `ss_n` falls.
- R5: `done` rises exactly H cycles after edge 16, and `rx_data` is updated in that same cycle. `done` then stays high until a `done_clr` pulse, and a set takes priority over a clear.
- R6: When no byte is waiting at completion, `ss_n` rises in the same cycle as `done`. It then stays high for at least H cycles before it falls again.
- R7: When a byte is waiting at completion, `ss_n` stays low and edge 1 of the next byte comes exactly H cycles after `done` is set.
- R8: `tx_ready` is high exactly when the holding slot is empty. A byte is accepted only when `tx_valid` and `tx_ready` are both high, and bytes leave in the order they were accepted.
- R9: `busy` is high from the fall of `ss_n` until the completion cycle. It stays high through that cycle only when a chained byte follows.
- R10: `mosi` is low whenever `ss_n` is high. After edge 16 it holds the last bit until `ss_n` rises or the next odd edge comes.
- R11: After reset, `ss_n`=1, `sck`=`cpol`, `mosi`=0, `done`=0, `busy`=0 and `tx_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | Serial clock idle level |
| lsb_first | input | 1 | 1 = least significant bit first |
| half_div | input | 8 | Half-period of `sck` minus one, in clock cycles |
| tx_data | input | 8 | Byte offered for sending |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | Holding slot is empty |
| rx_data | output | 8 | Last byte received |
| done | output | 1 | Sticky transfer-complete flag |
| done_clr | input | 1 | Write-one pulse that clears `done` |
| busy | output | 1 | A transfer is in progress |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
The in-line assertions check the invariants that must hold on every cycle:
- the idle clock level and a quiet `mosi` while `ss_n` is high;
- `busy` implying that the select line is asserted;
- the edge counter never passing 16;
- `mosi` staying still across a capture edge;
- a stalled offer leaving the held byte untouched;
- the flag staying sticky;
- the select line staying low on a chained completion.

Only the bench scenarios can show the exact lead, edge-to-edge and completion delays for each divider value, and the bit order of both directions. They also show the length of the idle gap and the byte order across chained bursts. A slave model driven from random data checks all of these against values it computes for itself.

// File: rtl/spi_m_pkg.sv
package spi_m_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TAIL,
    ST_GAP
  } spi_st_e;
endpackage

// File: rtl/spi_m_timer.sv
module spi_m_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= limit)); // R1
endmodule

// File: rtl/spi_m_shift.sv
module spi_m_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         lsb_first,
  input  logic         drive,
  input  logic         sample,
  input  logic         clear_out,
  input  logic         miso,
  output logic         mosi,
  output logic [W-1:0] rx_word
);
  logic [W-1:0] tx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr   <= '0;
      rx_word <= '0;
      mosi    <= 1'b0;
    end else begin
      if (load) begin
        tx_sr <= load_data;
      end else if (drive) begin
        mosi  <= lsb_first ? tx_sr[0] : tx_sr[W-1];
        tx_sr <= lsb_first ? (tx_sr >> 1) : (tx_sr << 1);
      end
      if (sample)
        rx_word <= lsb_first ? {miso, rx_word[W-1:1]} : {rx_word[W-2:0], miso};
      if (clear_out)
        mosi <= 1'b0;
    end
  end

  AST_LOAD_OFF_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !(drive || sample)); // R2
  AST_MOSI_STILL_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    sample |=> $stable(mosi)); // R2
endmodule

// File: rtl/spi_cpha1_master.sv
module spi_cpha1_master #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpol,
  input  logic              lsb_first,
  input  logic [DIV_W-1:0]  half_div,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              done,
  input  logic              done_clr,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              ss_n
);
  import spi_m_pkg::*;

  localparam int EDGES  = 2 * DATA_W;
  localparam int EDGE_W = $clog2(EDGES + 1);

  spi_st_e           state;
  logic [EDGE_W-1:0] edge_cnt;
  logic [EDGE_W-1:0] next_edge;
  logic              pend_full;
  logic [DATA_W-1:0] pend_data;
  logic [DIV_W-1:0]  div_q;
  logic              lsb_q;
  logic              phase;
  logic              tick;
  logic              accept;
  logic              take;
  logic              edge_go;
  logic              drive;
  logic              sample;
  logic              finish;
  logic              clear_out;
  logic [DATA_W-1:0] rx_word;

  assign tx_ready  = !pend_full;
  assign accept    = tx_valid && tx_ready;
  assign finish    = (state == ST_TAIL) && tick;
  assign take      = pend_full && ((state == ST_IDLE) || finish);
  assign edge_go   = tick && ((state == ST_LEAD) || (state == ST_SHIFT));
  assign next_edge = edge_cnt + 1'b1;
  assign drive     = edge_go && next_edge[0];
  assign sample    = edge_go && !next_edge[0];
  assign clear_out = finish && !pend_full;
  assign busy      = (state == ST_LEAD) || (state == ST_SHIFT) || (state == ST_TAIL);
  assign sck       = cpol ^ phase;

  spi_m_timer #(.DIV_W(DIV_W)) i_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state != ST_IDLE),
    .limit (div_q),
    .tick  (tick)
  );

  spi_m_shift #(.W(DATA_W)) i_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (take),
    .load_data (pend_data),
    .lsb_first (lsb_q),
    .drive     (drive),
    .sample    (sample),
    .clear_out (clear_out),
    .miso      (miso),
    .mosi      (mosi),
    .rx_word   (rx_word)
  );

  // holding slot, one entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_full <= 1'b0;
      pend_data <= '0;
    end else if (accept) begin
      pend_full <= 1'b1;
      pend_data <= tx_data;
    end else if (take) begin
      pend_full <= 1'b0;
    end
  end

  // sequencing of select, edges and completion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      edge_cnt <= '0;
      phase    <= 1'b0;
      ss_n     <= 1'b1;
      div_q    <= '0;
      lsb_q    <= 1'b0;
      done     <= 1'b0;
      rx_data  <= '0;
    end else begin
      if (take) begin
        div_q <= half_div;
        lsb_q <= lsb_first;
      end
      if (edge_go) begin
        phase    <= !phase;
        edge_cnt <= next_edge;
      end
      if (finish) begin
        done    <= 1'b1;
        rx_data <= rx_word;
      end else if (done_clr) begin
        done <= 1'b0;
      end
      case (state)
        ST_IDLE: if (take) begin
          ss_n     <= 1'b0;
          edge_cnt <= '0;
          state    <= ST_LEAD;
        end
        ST_LEAD: if (tick) state <= ST_SHIFT;
        ST_SHIFT: if (tick && (next_edge == EDGE_W'(EDGES))) state <= ST_TAIL;
        ST_TAIL: if (tick) begin
          edge_cnt <= '0;
          if (pend_full) begin
            state <= ST_LEAD;
          end else begin
            ss_n  <= 1'b1;
            state <= ST_GAP;
          end
        end
        ST_GAP: if (tick) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_CLOCK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |-> (sck == cpol)); // R1
  AST_EDGE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    edge_cnt <= EDGE_W'(EDGES)); // R1
  AST_BUSY_HAS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ss_n); // R9
  AST_STALL_KEEPS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> $stable(pend_data)); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_clr) |=> done); // R5
  AST_QUIET_MOSI: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |-> !mosi); // R10
  AST_CHAIN_HOLDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && pend_full) |=> !ss_n); // R7
endmodule

// File: tb/test_spi_cpha1_master.sv
module test_spi_cpha1_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpol = 1'b0;
  logic       lsb_first = 1'b0;
  logic [7:0] half_div = 8'd0;
  logic [7:0] tx_data = 8'd0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] rx_data;
  logic       done;
  logic       done_clr = 1'b0;
  logic       busy;
  logic       sck;
  logic       mosi;
  logic       miso = 1'b0;
  logic       ss_n;

  always #2.5 clk = ~clk;

  spi_cpha1_master i_spi_cpha1_master (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .lsb_first(lsb_first),
    .half_div(half_div), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .done(done), .done_clr(done_clr),
    .busy(busy), .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  int n_chk = 0;
  int n_bad = 0;
  int hp = 1;
  logic [7:0] sent_q [0:255];
  int wr_idx = 0;
  int rd_idx = 0;
  logic [7:0] slv_tx = 8'h00;
  int cyc = 0;
  int edge_n = 0;
  int t_ref = 0;
  int t_last = 0;
  int t_due = -1;
  int t_rise = -1000;
  bit first_in_burst = 1'b0;
  logic prev_sck = 1'b0;
  logic prev_ss = 1'b1;
  logic prev_done = 1'b0;
  bit mon_on = 1'b0;

  function automatic logic exp_bit(logic [7:0] b, int idx, logic lsb);
    return lsb ? b[idx] : b[7-idx];
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // slave model and timing monitor
  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      if (prev_ss && !ss_n) begin
        chk(cyc - t_rise >= hp, "R6 idle gap", cyc - t_rise, hp);
        chk(busy == 1'b1, "R9 busy at select", busy, 1);
        t_ref = cyc; edge_n = 0; first_in_burst = 1'b1;
        slv_tx = 8'($urandom);
      end
      if (!prev_ss && ss_n) begin
        t_rise = cyc;
        chk(mosi == 1'b0, "R10 mosi low at release", mosi, 0);
      end
      if (!ss_n && sck != prev_sck) begin
        edge_n++;
        if (edge_n == 1) chk(cyc - t_ref == hp, "R4/R7 first edge delay", cyc - t_ref, hp);
        else chk(cyc - t_last == hp, "R1 edge spacing", cyc - t_last, hp);
        t_last = cyc;
        chk(sck == ((edge_n % 2 == 1) ? !cpol : cpol), "R1 edge direction", sck, (edge_n % 2 == 1) ? !cpol : cpol);
        chk(mosi == exp_bit(sent_q[rd_idx[7:0]], (edge_n - 1) / 2, lsb_first), "R2/R3 mosi bit",
            mosi, exp_bit(sent_q[rd_idx[7:0]], (edge_n - 1) / 2, lsb_first));
        if (edge_n % 2 == 1) miso = exp_bit(slv_tx, (edge_n - 1) / 2, lsb_first);
        if (edge_n == 16) t_due = cyc + hp;
      end
      if (cyc == t_due) begin
        automatic bit chain = (wr_idx > rd_idx + 1);
        chk(edge_n == 16, "R1 edge count", edge_n, 16);
        if (first_in_burst) chk(prev_done == 1'b0, "R5 done not early", prev_done, 0);
        chk(done == 1'b1, "R5 done set", done, 1);
        chk(rx_data == slv_tx, "R3/R5 rx byte", rx_data, slv_tx);
        chk(ss_n == !chain, "R6/R7 select at completion", ss_n, !chain);
        chk(busy == chain, "R9 busy at completion", busy, chain);
        rd_idx++;
        t_due = -1; first_in_burst = 1'b0;
        if (chain) begin
          t_ref = cyc; edge_n = 0; slv_tx = 8'($urandom);
        end
      end
    end
    prev_sck = sck; prev_ss = ss_n; prev_done = done;
  end

  task automatic push(logic [7:0] b);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = b;
    while (!tx_ready) @(negedge clk);
    @(posedge clk);
    sent_q[wr_idx[7:0]] = b;
    wr_idx++;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (rd_idx != wr_idx || !ss_n) @(negedge clk);
    repeat (hp + 2) @(negedge clk);
  endtask

  task automatic burst(logic cp, logic lsb, logic [7:0] dv, int n);
    @(negedge clk);
    cpol = cp; lsb_first = lsb; half_div = dv; hp = int'(dv) + 1;
    #1;
    chk(sck == cp, "R1 idle level", sck, cp);
    for (int k = 0; k < n; k++) begin
      push(8'($urandom));
      if (k == 1) chk(tx_ready == 1'b0, "R8 slot full back-pressure", tx_ready, 0);
    end
    wait_idle();
    chk(done == 1'b1, "R5 done sticky", done, 1);
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
    chk(done == 1'b0, "R5 done cleared", done, 0);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    chk(ss_n == 1'b1, "R11 reset ss_n", ss_n, 1);
    chk(sck == 1'b0, "R11 reset sck", sck, 0);
    chk(mosi == 1'b0, "R11 reset mosi", mosi, 0);
    chk(done == 1'b0, "R11 reset done", done, 0);
    chk(busy == 1'b0, "R11 reset busy", busy, 0);
    chk(tx_ready == 1'b1, "R11 reset ready", tx_ready, 1);
    rst_n = 1'b1;
    mon_on = 1'b1;
    burst(1'b0, 1'b0, 8'd0, 1);
    burst(1'b1, 1'b1, 8'd0, 1);
    burst(1'b0, 1'b1, 8'd1, 3);
    burst(1'b1, 1'b0, 8'd3, 2);
    burst(1'b1, 1'b1, 8'd7, 3);
    for (int i = 0; i < 16; i++)
      burst(1'($urandom), 1'($urandom), 8'($urandom % 6), 1 + int'($urandom % 3));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule